// File: doc/BRIEF.md
# Serial Receive Start Sequencer

This block opens a serial read. Loading a read instruction raises a level input. When the transmitter is also held idle, a start flop sets on the next falling clock edge and turns on a free-running 4-bit bit-timing counter. The counter advances on every high-to-low transition of the system clock. Two decoded ticks come from it: one at count 6 and one at count 7.

During the high half of the clock period in which the count holds 6, the block sends out one clear pulse for the data register and the start-bit flop. The pulse appears in both polarities, and a transmit-reset strobe goes with it. The pulse is only produced while the datapath reports data-ready. A second flop sets on the falling edge that ends count 6. That flop marks the end of the start phase and blocks any later clear pulse.

All state moves on the falling clock edge. A synchronous reset, or the loss of either enabling level, returns both flops and the counter to zero at the next falling edge.

Top module: `rx_start_seq`

## Requirements
- R1: When `rd_instr` and `xmit_off` are both high at a falling clock edge, `cnt_en` is high after that edge, and it stays high while both levels stay high.
- R2: While `xmit_off` is low, `cnt_en`, `bit_cnt`, `start_done` and all pulses stay at their idle values, even when `rd_instr` is high.
- R3: While `cnt_en` is high, `bit_cnt` rises by one at each falling edge. The edge that sets `cnt_en` leaves it at 0. The count wraps from 15 to 0.
- R4: `tick_a` is high exactly when `cnt_en` is high and `bit_cnt` equals 6. `tick_b` is high exactly when `cnt_en` is high and `bit_cnt` equals 7.
- R5: `clr_p` is high only during the high half of the clock, and only while `bit_cnt` is 6, `start_done` is low and `data_rdy` is high. It first appears in the high half that follows the sixth falling edge after the arming edge.
- R6: `clr_n` and `txrst_n` are always the inverse of `clr_p`.
- R7: While `data_rdy` is low, `clr_p` stays low. The counter and `start_done` still advance.
- R8: `start_done` sets at the falling edge that moves `bit_cnt` from 6 to 7. It stays set until cleared, and no further `clr_p` occurs while it is set, including when the count wraps back to 6.
- R9: `rst` high, or `rd_instr` low, at a falling edge clears `cnt_en`, `bit_cnt` and `start_done`. When both inputs allow it again, a fresh start takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; state changes on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_instr | input | 1 | Read instruction level from the control register |
| xmit_off | input | 1 | Transmitter-held-idle level from the control register |
| data_rdy | input | 1 | Datapath ready-for-read status |
| cnt_en | output | 1 | Start flop, enables the bit-timing counter |
| bit_cnt | output | 4 | Bit-timing count |
| tick_a | output | 1 | Count-6 decode |
| tick_b | output | 1 | Count-7 decode |
| clr_p | output | 1 | Clear pulse, active high |
| clr_n | output | 1 | Clear pulse, active low |
| txrst_n | output | 1 | Transmit-reset strobe, active low |
| start_done | output | 1 | Start phase finished |

## Verification
A counter that misses or repeats a step shows on `bit_cnt` at the very next falling edge. Through the decodes it also moves `tick_a`, `tick_b` and the clear pulse by whole clock periods, so a wrong count is visible within one period. A start flop that is stuck, or that arms without the transmitter being idle, shows on `cnt_en` one edge after arming. A phase flop that sets early, late or never changes `start_done` at the seventh edge after arming. It also shows as a missing clear pulse, or as a second pulse once the count wraps to 6 again about sixteen periods later. For that reason the sweep runs well past one wrap.

// File: rtl/rx_start_seq.sv
module rx_start_seq #(
  parameter int CW     = 4,
  parameter int CLR_AT = 6,
  parameter int ALT_AT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_instr,
  input  logic          xmit_off,
  input  logic          data_rdy,
  output logic          cnt_en,
  output logic [CW-1:0] bit_cnt,
  output logic          tick_a,
  output logic          tick_b,
  output logic          clr_p,
  output logic          clr_n,
  output logic          txrst_n,
  output logic          start_done
);

  localparam logic [CW-1:0] CLR_V = CW'(CLR_AT);
  localparam logic [CW-1:0] ALT_V = CW'(ALT_AT);

  logic          armed;
  logic          run;
  logic          done;
  logic [CW-1:0] cnt;

  assign armed = rd_instr & xmit_off;

  always_ff @(negedge clk) begin
    if (rst || !armed) begin
      run  <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      run <= 1'b1;
      if (run) cnt <= cnt + 1'b1;
      if (run && cnt == CLR_V) done <= 1'b1;
    end
  end

  assign cnt_en     = run;
  assign bit_cnt    = cnt;
  assign start_done = done;
  assign tick_a     = run & (cnt == CLR_V);
  assign tick_b     = run & (cnt == ALT_V);
  assign clr_p      = tick_a & clk & ~done & data_rdy;
  assign clr_n      = ~clr_p;
  assign txrst_n    = ~clr_p;

  // R3
  cnt_step_chk: assert property (@(negedge clk) disable iff (rst)
    (cnt_en && $past(cnt_en)) |-> bit_cnt == CW'($past(bit_cnt) + 1'b1));

  // R8
  done_rise_chk: assert property (@(negedge clk) disable iff (rst)
    $rose(start_done) |-> bit_cnt == ALT_V);

  // R4
  tick_excl_chk: assert property (@(negedge clk) disable iff (rst)
    $onehot0({tick_a, tick_b}));

  // R1
  done_needs_run_chk: assert property (@(negedge clk) disable iff (rst)
    start_done |-> cnt_en);

  // R9
  drop_clear_chk: assert property (@(negedge clk) disable iff (rst)
    !rd_instr |=> (!cnt_en && bit_cnt == '0 && !start_done));

endmodule

// File: tb/rx_start_seq_tb.sv
module rx_start_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_instr = 1'b0;
  logic       xmit_off = 1'b0;
  logic       data_rdy = 1'b0;
  logic       cnt_en, tick_a, tick_b, clr_p, clr_n, txrst_n, start_done;
  logic [3:0] bit_cnt;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;

  rx_start_seq u_dut (
    .clk(clk), .rst(rst), .rd_instr(rd_instr), .xmit_off(xmit_off), .data_rdy(data_rdy),
    .cnt_en(cnt_en), .bit_cnt(bit_cnt), .tick_a(tick_a), .tick_b(tick_b),
    .clr_p(clr_p), .clr_n(clr_n), .txrst_n(txrst_n), .start_done(start_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_chk(input string req);
    chk({req, " cnt_en"}, cnt_en, 0);
    chk({req, " bit_cnt"}, bit_cnt, 0);
    chk({req, " start_done"}, start_done, 0);
    chk({req, " tick_a"}, tick_a, 0);
    chk({req, " tick_b"}, tick_b, 0);
    chk({req, " clr_p"}, clr_p, 0);
  endtask

  // Arming edge is the next falling edge; k counts falling edges from it.
  task automatic sweep(input bit dr, input bit xo, input int n);
    for (int k = 0; k < n; k++) begin
      int ec, ed, ep;
      @(negedge clk); #1;
      ec = xo ? (k % 16) : 0;
      ed = (xo && k >= 7) ? 1 : 0;
      chk("R1 R2 cnt_en", cnt_en, xo ? 1 : 0);
      chk("R3 bit_cnt", bit_cnt, ec);
      chk("R4 tick_a", tick_a, (xo && ec == 6) ? 1 : 0);
      chk("R4 tick_b", tick_b, (xo && ec == 7) ? 1 : 0);
      chk("R8 start_done", start_done, ed);
      chk("R5 clr_p low phase", clr_p, 0);
      @(posedge clk); #1;
      ep = (xo && dr && k == 6) ? 1 : 0;
      chk("R5 R7 R8 clr_p high phase", clr_p, ep);
      chk("R6 clr_n", clr_n, 1 - ep);
      chk("R6 txrst_n", txrst_n, 1 - ep);
    end
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    rd_instr = 1'b1; xmit_off = 1'b1; data_rdy = 1'b1;
    @(negedge clk); #1;
    idle_chk("R9 reset");
    @(posedge clk); #1;
    rst = 1'b0;
    for (int dr = 0; dr < 2; dr++)
      for (int xo = 0; xo < 2; xo++) begin
        @(posedge clk); #1;
        rd_instr = 1'b0;
        @(negedge clk); #1;
        idle_chk("R9 drop");
        @(posedge clk); #1;
        rd_instr = 1'b1; xmit_off = xo[0]; data_rdy = dr[0];
        sweep(dr[0], xo[0], 26);
      end
    @(posedge clk); #1;
    rd_instr = 1'b0;
    @(negedge clk); #1;
    idle_chk("R9 drop");
    @(posedge clk); #1;
    rd_instr = 1'b1; xmit_off = 1'b1; data_rdy = 1'b1;
    sweep(1'b1, 1'b1, 4);
    @(posedge clk); #1;
    rst = 1'b1;
    @(negedge clk); #1;
    idle_chk("R9 sync reset");
    @(posedge clk); #1;
    rst = 1'b0;
    sweep(1'b1, 1'b1, 10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule